// File: doc/BRIEF.md
# Predicated Register File with Deferred-Exception Tracking

This block holds the integer architectural state of a small predicated, speculative core: a bank of general registers, each paired with a deferred-exception flag (called NaT, "not a thing"), and a bank of one-bit predicates. Two combinational read ports serve the general registers and a third serves the qualifying-predicate lookup. In each cycle one operation is presented. It may write one general register or a pair of predicates. It commits at the next rising clock edge, and only when its qualifying predicate reads one.

The operation kind decides how the deferred-exception flag moves. A plain, non-speculative write that consumes a flagged source raises a fault and is dropped. Speculative operations carry flags forward instead of faulting. A speculative load plants a flag when its access would have excepted. Compares write a true/false predicate pair, and they clear both predicates when a used source is flagged. A flag test turns a register's flag into a predicate pair. Register 0 and its flag are hardwired to zero, and predicate 0 is hardwired to one.

Top module: `pred_regfile`

## Requirements
- R1: After reset every general register reads data 0 with flag 0, predicate 0 reads 1 and every other predicate reads 0.
- R2: General register 0 always reads data 0 and flag 0. Writes to it are ignored, including a speculative load with an exception.
- R3: Predicate 0 always reads 1. A predicate write aimed at index 0 is ignored, and the other target of the same operation is still written.
- R4: Reads are combinational. Writes take effect at the rising edge, so a read of the register being written in the same cycle returns the old value.
- R5: When the predicate selected by `qp_idx` reads 0, the operation changes no register, no flag and no predicate, and `nat_fault` stays 0.
- R6: A plain write (`op_kind`=1) whose used sources are unflagged stores `wr_data` with flag 0. `src_use` bit 0 selects read port A as a source and bit 1 selects port B.
- R7: A plain write with a used flagged source drives `nat_fault` high in the same cycle, and the destination keeps its old data and flag.
- R8: A speculative load (`op_kind`=3) stores `wr_data` with flag equal to `load_exc` OR'd with the flags of its used sources.
- R9: A speculative operation (`op_kind`=2) stores `wr_data` with flag equal to the OR of the flags of its used sources only.
- R10: A compare (`op_kind`=4) with no used flagged source writes `cmp_res` to predicate `pd1_idx` and its complement to `pd2_idx`. Flags on unused ports do not matter.
- R11: A compare with any used flagged source writes 0 to both predicate targets.
- R12: A flag test (`op_kind`=5) writes the flag of the register on read port A to `pd1_idx` and its complement to `pd2_idx`.
- R13: When `pd1_idx` equals `pd2_idx`, the second target's value is the one kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_data | output | 64 | Read port A data |
| rd_a_nat | output | 1 | Read port A deferred-exception flag |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_data | output | 64 | Read port B data |
| rd_b_nat | output | 1 | Read port B deferred-exception flag |
| qp_idx | input | 6 | Qualifying predicate index |
| qp_val | output | 1 | Value of the qualifying predicate |
| op_kind | input | 3 | 0 none, 1 plain write, 2 speculative op, 3 speculative load, 4 compare, 5 flag test |
| src_use | input | 2 | Bit 0: port A is a source; bit 1: port B is a source |
| wr_idx | input | 5 | Destination general register |
| wr_data | input | 64 | Result to write |
| load_exc | input | 1 | Speculative load met an exception |
| cmp_res | input | 1 | Compare outcome |
| pd1_idx | input | 6 | First predicate target |
| pd2_idx | input | 6 | Second predicate target |
| nat_fault | output | 1 | Consumption fault on a plain write |

## Verification
The hardest situation to reach is a flag on a source that is present but ignored, because the port is not marked as used. To get there, a register must first be flagged through a speculative load. It is then read on one port while the other port carries the only source that counts. The bench builds this state once in its vector table and then reuses the flagged register across speculative, plain, compare and flag-test operations. It also runs a compare whose flagged register sits on an unused port, and a faulting write issued under a false predicate. In both cases the fault output and the observable state must show no effect.

// File: rtl/prf_pkg.sv
package prf_pkg;

   typedef enum logic [2:0] {
      OP_NONE  = 3'd0,
      OP_PLAIN = 3'd1,
      OP_SPEC  = 3'd2,
      OP_SLOAD = 3'd3,
      OP_CMP   = 3'd4,
      OP_TNAT  = 3'd5
   } op_kind_e;

   localparam int unsigned SRC_PORTS = 2;

endpackage

// File: rtl/prf_gr_bank.sv
module prf_gr_bank #(
   parameter int unsigned NUM_GR = 32,
   parameter int unsigned DATA_W = 64,
   localparam int unsigned IDX_W = $clog2(NUM_GR)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  ra_idx,
   output logic [DATA_W-1:0] ra_data,
   output logic              ra_nat,
   input  logic [IDX_W-1:0]  rb_idx,
   output logic [DATA_W-1:0] rb_data,
   output logic              rb_nat,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wnat
);

   logic [DATA_W-1:0] mem  [NUM_GR];
   logic              flag [NUM_GR];

   for (genvar i = 0; i < NUM_GR; i++) begin : g_reg
      if (i == 0) begin : g_zero
         assign mem[i]  = '0;
         assign flag[i] = 1'b0;
      end else begin : g_store
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mem[i]  <= '0;
               flag[i] <= 1'b0;
            end else if (we && (widx == IDX_W'(i))) begin
               mem[i]  <= wdata;
               flag[i] <= wnat;
            end
         end
      end
   end

   assign ra_data = mem[ra_idx];
   assign ra_nat  = flag[ra_idx];
   assign rb_data = mem[rb_idx];
   assign rb_nat  = flag[rb_idx];

   AST_GR_WRITE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
      (we && widx != '0) |=> (ra_idx != $past(widx) ||
                              (ra_data == $past(wdata) && ra_nat == $past(wnat)))); // R4

   AST_GR0_STAYS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (we && widx == '0) |=> (rb_idx != '0 || (rb_data == '0 && !rb_nat))); // R2

endmodule

// File: rtl/prf_pr_bank.sv
module prf_pr_bank #(
   parameter int unsigned NUM_PR = 64,
   localparam int unsigned IDX_W = $clog2(NUM_PR)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] qidx,
   output logic             qval,
   input  logic             we1,
   input  logic [IDX_W-1:0] widx1,
   input  logic             wd1,
   input  logic             we2,
   input  logic [IDX_W-1:0] widx2,
   input  logic             wd2
);

   logic bits [NUM_PR];

   for (genvar i = 0; i < NUM_PR; i++) begin : g_pred
      if (i == 0) begin : g_true
         assign bits[i] = 1'b1;
      end else begin : g_store
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               bits[i] <= 1'b0;
            end else if (we2 && (widx2 == IDX_W'(i))) begin
               bits[i] <= wd2;
            end else if (we1 && (widx1 == IDX_W'(i))) begin
               bits[i] <= wd1;
            end
         end
      end
   end

   assign qval = bits[qidx];

   AST_PR_SECOND_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (we2 && widx2 != '0) |=> (qidx != $past(widx2) || qval == $past(wd2))); // R13

   AST_P0_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      ((we1 && widx1 == '0) || (we2 && widx2 == '0)) |=> (qidx != '0 || qval)); // R3

endmodule

// File: rtl/prf_op_ctrl.sv
module prf_op_ctrl
   import prf_pkg::*;
(
   input  op_kind_e                kind,
   input  logic [SRC_PORTS-1:0]    src_use,
   input  logic                    nat_a,
   input  logic                    nat_b,
   input  logic                    qp,
   input  logic                    load_exc,
   input  logic                    cmp_res,
   output logic                    gr_we,
   output logic                    gr_wnat,
   output logic                    pr_we1,
   output logic                    pr_wd1,
   output logic                    pr_we2,
   output logic                    pr_wd2,
   output logic                    fault
);

   logic src_nat;

   assign src_nat = (src_use[0] & nat_a) | (src_use[1] & nat_b);

   always_comb begin
      gr_we   = 1'b0;
      gr_wnat = 1'b0;
      pr_we1  = 1'b0;
      pr_wd1  = 1'b0;
      pr_we2  = 1'b0;
      pr_wd2  = 1'b0;
      fault   = 1'b0;
      unique case (kind)
         OP_PLAIN: begin
            fault = qp & src_nat;
            gr_we = qp & ~src_nat;
         end
         OP_SPEC: begin
            gr_we   = qp;
            gr_wnat = src_nat;
         end
         OP_SLOAD: begin
            gr_we   = qp;
            gr_wnat = load_exc | src_nat;
         end
         OP_CMP: begin
            pr_we1 = qp;
            pr_we2 = qp;
            pr_wd1 = ~src_nat & cmp_res;
            pr_wd2 = ~src_nat & ~cmp_res;
         end
         OP_TNAT: begin
            pr_we1 = qp;
            pr_we2 = qp;
            pr_wd1 = nat_a;
            pr_wd2 = ~nat_a;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/pred_regfile.sv
module pred_regfile
   import prf_pkg::*;
#(
   parameter int unsigned NUM_GR = 32,
   parameter int unsigned DATA_W = 64,
   parameter int unsigned NUM_PR = 64,
   localparam int unsigned GR_IDX_W = $clog2(NUM_GR),
   localparam int unsigned PR_IDX_W = $clog2(NUM_PR)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [GR_IDX_W-1:0]  rd_a_idx,
   output logic [DATA_W-1:0]    rd_a_data,
   output logic                 rd_a_nat,
   input  logic [GR_IDX_W-1:0]  rd_b_idx,
   output logic [DATA_W-1:0]    rd_b_data,
   output logic                 rd_b_nat,
   input  logic [PR_IDX_W-1:0]  qp_idx,
   output logic                 qp_val,
   input  logic [2:0]           op_kind,
   input  logic [1:0]           src_use,
   input  logic [GR_IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic                 load_exc,
   input  logic                 cmp_res,
   input  logic [PR_IDX_W-1:0]  pd1_idx,
   input  logic [PR_IDX_W-1:0]  pd2_idx,
   output logic                 nat_fault
);

   if (NUM_GR < 2 || (1 << GR_IDX_W) != NUM_GR) begin : g_bad_gr
      $error("NUM_GR must be a power of two of at least 2");
   end
   if (NUM_PR < 2 || (1 << PR_IDX_W) != NUM_PR) begin : g_bad_pr
      $error("NUM_PR must be a power of two of at least 2");
   end
   if (DATA_W < 1) begin : g_bad_w
      $error("DATA_W must be positive");
   end

   op_kind_e kind;
   logic gr_we, gr_wnat, pr_we1, pr_wd1, pr_we2, pr_wd2;

   assign kind = op_kind_e'(op_kind);

   prf_gr_bank #(.NUM_GR(NUM_GR), .DATA_W(DATA_W)) i_gr (
      .clk     (clk),
      .rst_n   (rst_n),
      .ra_idx  (rd_a_idx),
      .ra_data (rd_a_data),
      .ra_nat  (rd_a_nat),
      .rb_idx  (rd_b_idx),
      .rb_data (rd_b_data),
      .rb_nat  (rd_b_nat),
      .we      (gr_we),
      .widx    (wr_idx),
      .wdata   (wr_data),
      .wnat    (gr_wnat)
   );

   prf_pr_bank #(.NUM_PR(NUM_PR)) i_pr (
      .clk   (clk),
      .rst_n (rst_n),
      .qidx  (qp_idx),
      .qval  (qp_val),
      .we1   (pr_we1),
      .widx1 (pd1_idx),
      .wd1   (pr_wd1),
      .we2   (pr_we2),
      .widx2 (pd2_idx),
      .wd2   (pr_wd2)
   );

   prf_op_ctrl i_ctrl (
      .kind     (kind),
      .src_use  (src_use),
      .nat_a    (rd_a_nat),
      .nat_b    (rd_b_nat),
      .qp       (qp_val),
      .load_exc (load_exc),
      .cmp_res  (cmp_res),
      .gr_we    (gr_we),
      .gr_wnat  (gr_wnat),
      .pr_we1   (pr_we1),
      .pr_wd1   (pr_wd1),
      .pr_we2   (pr_we2),
      .pr_wd2   (pr_wd2),
      .fault    (nat_fault)
   );

   AST_NULLIFIED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !qp_val |-> (!gr_we && !pr_we1 && !pr_we2 && !nat_fault)); // R5

   AST_FAULT_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      nat_fault |=> (rd_a_idx != $past(wr_idx) ||
                     (rd_a_data == $past(rd_a_data) && rd_a_nat == $past(rd_a_nat)) ||
                     $past(rd_a_idx) != $past(wr_idx))); // R7

   AST_CMP_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == OP_CMP && qp_val && ((src_use[0] && rd_a_nat) || (src_use[1] && rd_b_nat)))
         |-> (pr_we1 && pr_we2 && !pr_wd1 && !pr_wd2)); // R11

   AST_TNAT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == OP_TNAT && qp_val) |-> (pr_wd1 == rd_a_nat && pr_wd2 != rd_a_nat)); // R12

endmodule

// File: tb/test_pred_regfile.sv
module test_pred_regfile;
   import prf_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 10;

   typedef struct packed {
      logic [2:0]  kind;
      logic [5:0]  qp;
      logic [1:0]  srcm;
      logic [4:0]  ra;
      logic [4:0]  rb;
      logic [4:0]  wi;
      logic [15:0] wd;
      logic        exc;
      logic        ef;
      logic [15:0] ed;
      logic        en;
   } vec_t;

   // kind, qp, srcm, ra, rb, wi, wd, exc, exp_fault, exp_data, exp_nat
   localparam vec_t VECS [NV] = '{
      '{3'd1, 6'd0,  2'b00, 5'd0, 5'd0, 5'd3, 16'h1111, 1'b0, 1'b0, 16'h1111, 1'b0}, // R6
      '{3'd3, 6'd0,  2'b00, 5'd0, 5'd0, 5'd4, 16'h2222, 1'b1, 1'b0, 16'h2222, 1'b1}, // R8
      '{3'd3, 6'd0,  2'b00, 5'd0, 5'd0, 5'd6, 16'h3333, 1'b0, 1'b0, 16'h3333, 1'b0}, // R8
      '{3'd2, 6'd0,  2'b01, 5'd4, 5'd0, 5'd7, 16'h0044, 1'b0, 1'b0, 16'h0044, 1'b1}, // R9
      '{3'd2, 6'd0,  2'b10, 5'd4, 5'd3, 5'd8, 16'h0088, 1'b0, 1'b0, 16'h0088, 1'b0}, // R9
      '{3'd1, 6'd0,  2'b01, 5'd4, 5'd0, 5'd3, 16'h5555, 1'b0, 1'b1, 16'h1111, 1'b0}, // R7
      '{3'd1, 6'd0,  2'b01, 5'd3, 5'd0, 5'd9, 16'h0066, 1'b0, 1'b0, 16'h0066, 1'b0}, // R6
      '{3'd1, 6'd0,  2'b00, 5'd0, 5'd0, 5'd0, 16'h0077, 1'b0, 1'b0, 16'h0000, 1'b0}, // R2
      '{3'd3, 6'd0,  2'b00, 5'd0, 5'd0, 5'd0, 16'h0000, 1'b1, 1'b0, 16'h0000, 1'b0}, // R2
      '{3'd1, 6'd10, 2'b00, 5'd0, 5'd0, 5'd9, 16'h0099, 1'b0, 1'b0, 16'h0066, 1'b0}  // R5
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
   logic [63:0] rd_a_data, rd_b_data, wr_data = '0;
   logic        rd_a_nat, rd_b_nat, qp_val, nat_fault;
   logic [5:0]  qp_idx = '0, pd1_idx = '0, pd2_idx = '0;
   logic [2:0]  op_kind = '0;
   logic [1:0]  src_use = '0;
   logic        load_exc = 1'b0, cmp_res = 1'b0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pred_regfile i_pred_regfile (
      .clk(clk), .rst_n(rst_n),
      .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data), .rd_a_nat(rd_a_nat),
      .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .rd_b_nat(rd_b_nat),
      .qp_idx(qp_idx), .qp_val(qp_val),
      .op_kind(op_kind), .src_use(src_use),
      .wr_idx(wr_idx), .wr_data(wr_data), .load_exc(load_exc), .cmp_res(cmp_res),
      .pd1_idx(pd1_idx), .pd2_idx(pd2_idx), .nat_fault(nat_fault)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle();
      op_kind = 3'd0; src_use = 2'b00; load_exc = 1'b0; cmp_res = 1'b0;
      qp_idx = 6'd0;
   endtask

   task automatic rd_gr(input logic [4:0] idx, output logic [63:0] d, output logic n);
      idle();
      rd_a_idx = idx;
      #1;
      d = rd_a_data;
      n = rd_a_nat;
   endtask

   task automatic rd_pr(input logic [5:0] idx, output logic v);
      idle();
      qp_idx = idx;
      #1;
      v = qp_val;
   endtask

   task automatic pred_op(input logic [2:0] k, input logic [5:0] qp, input logic [1:0] sm,
                          input logic [4:0] ra, input logic [4:0] rb,
                          input logic [5:0] p1, input logic [5:0] p2, input logic c);
      @(negedge clk);
      op_kind = k; qp_idx = qp; src_use = sm; rd_a_idx = ra; rd_b_idx = rb;
      pd1_idx = p1; pd2_idx = p2; cmp_res = c;
      @(posedge clk);
      #1;
      idle();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual hung expected finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [63:0] d;
      logic        n, v;

      repeat (3) @(posedge clk);
      #1;
      rd_gr(5'd5, d, n);  chk("R1 r5 data", d, 64'h0);  chk("R1 r5 nat", {63'b0, n}, 64'h0);
      rd_gr(5'd31, d, n); chk("R1 r31 data", d, 64'h0);
      rd_pr(6'd0, v);  chk("R1 p0", {63'b0, v}, 64'h1);
      rd_pr(6'd63, v); chk("R1 p63", {63'b0, v}, 64'h0);
      rd_pr(6'd10, v); chk("R1 p10", {63'b0, v}, 64'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // vector table: operation, fault in-cycle, destination after the edge
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         op_kind = VECS[i].kind; qp_idx = VECS[i].qp; src_use = VECS[i].srcm;
         rd_a_idx = VECS[i].ra; rd_b_idx = VECS[i].rb; wr_idx = VECS[i].wi;
         wr_data = {48'h0, VECS[i].wd}; load_exc = VECS[i].exc;
         #2;
         chk($sformatf("vec%0d fault R7", i), {63'b0, nat_fault}, {63'b0, VECS[i].ef});
         @(posedge clk);
         #1;
         rd_gr(VECS[i].wi, d, n);
         chk($sformatf("vec%0d data R6/R8/R9", i), d, {48'h0, VECS[i].ed});
         chk($sformatf("vec%0d nat R8/R9", i), {63'b0, n}, {63'b0, VECS[i].en});
      end

      // R10: clean compare, pair gets result and complement
      pred_op(3'd4, 6'd0, 2'b11, 5'd3, 5'd6, 6'd10, 6'd11, 1'b1);
      rd_pr(6'd10, v); chk("R10 pd1", {63'b0, v}, 64'h1);
      rd_pr(6'd11, v); chk("R10 pd2", {63'b0, v}, 64'h0);

      // R5: faulting plain write under false predicate p11
      @(negedge clk);
      op_kind = 3'd1; qp_idx = 6'd11; src_use = 2'b01; rd_a_idx = 5'd4;
      wr_idx = 5'd9; wr_data = 64'h77;
      #2;
      chk("R5 fault under false predicate", {63'b0, nat_fault}, 64'h0);
      @(posedge clk);
      #1;
      rd_gr(5'd9, d, n); chk("R5 r9 unchanged", d, 64'h66);
      // R5: nullified compare keeps predicates
      pred_op(3'd4, 6'd11, 2'b00, 5'd0, 5'd0, 6'd10, 6'd11, 1'b0);
      rd_pr(6'd10, v); chk("R5 p10 kept", {63'b0, v}, 64'h1);

      // R11: compare with flagged source clears both
      pred_op(3'd4, 6'd0, 2'b01, 5'd3, 5'd0, 6'd12, 6'd13, 1'b0);
      rd_pr(6'd13, v); chk("R10 p13 set", {63'b0, v}, 64'h1);
      pred_op(3'd4, 6'd0, 2'b01, 5'd4, 5'd0, 6'd12, 6'd13, 1'b1);
      rd_pr(6'd12, v); chk("R11 pd1 cleared", {63'b0, v}, 64'h0);
      rd_pr(6'd13, v); chk("R11 pd2 cleared", {63'b0, v}, 64'h0);
      // R10: flagged register on unused port is ignored
      pred_op(3'd4, 6'd0, 2'b10, 5'd4, 5'd3, 6'd14, 6'd15, 1'b1);
      rd_pr(6'd14, v); chk("R10 unused port pd1", {63'b0, v}, 64'h1);

      // R12: flag test
      pred_op(3'd5, 6'd0, 2'b00, 5'd4, 5'd0, 6'd20, 6'd21, 1'b0);
      rd_pr(6'd20, v); chk("R12 flagged pd1", {63'b0, v}, 64'h1);
      rd_pr(6'd21, v); chk("R12 flagged pd2", {63'b0, v}, 64'h0);
      pred_op(3'd5, 6'd0, 2'b00, 5'd3, 5'd0, 6'd20, 6'd21, 1'b0);
      rd_pr(6'd20, v); chk("R12 clean pd1", {63'b0, v}, 64'h0);
      rd_pr(6'd21, v); chk("R12 clean pd2", {63'b0, v}, 64'h1);

      // R13: same target index, second value kept
      pred_op(3'd4, 6'd0, 2'b00, 5'd0, 5'd0, 6'd22, 6'd22, 1'b1);
      rd_pr(6'd22, v); chk("R13 same index", {63'b0, v}, 64'h0);

      // R3: write aimed at p0 ignored, partner still written
      pred_op(3'd4, 6'd0, 2'b00, 5'd0, 5'd0, 6'd0, 6'd23, 1'b0);
      rd_pr(6'd0, v);  chk("R3 p0 still one", {63'b0, v}, 64'h1);
      rd_pr(6'd23, v); chk("R3 partner written", {63'b0, v}, 64'h1);

      // R4: same-cycle read returns old value
      @(negedge clk);
      op_kind = 3'd1; qp_idx = 6'd0; src_use = 2'b00; rd_a_idx = 5'd9;
      wr_idx = 5'd9; wr_data = 64'hAB;
      #2;
      chk("R4 old value in write cycle", rd_a_data, 64'h66);
      @(posedge clk);
      #1;
      idle();
      #1;
      chk("R4 new value after edge", rd_a_data, 64'hAB);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule